// File: doc/BRIEF.md
# Timed-Instruction Issuing Core

This block is a small in-order scalar core that runs a program held in its own instruction memory. Instructions fall into two classes. Classical instructions run to completion inside the core: register moves, additions, counted loops, absolute jumps, and writes that only change a set of latched output parameters. Timed instructions are not executed here. The core hands each one to a downstream timing queue together with a copy of every latched parameter as it stands at that moment, so parameters set earlier take effect together when the timed instruction later runs.

A host fills the instruction memory through a write port while the core is stopped, then pulses `start`. Execution always begins at address 0 and retires at most one instruction per clock. When the downstream queue reports full, a pending timed instruction waits and the core makes no progress until a slot frees up. The stop instruction is itself pushed into the queue to mark the end of the sequence, and the core then halts. Each instruction word is 64 bits: opcode in [63:56], operand fields A, B and C in [55:48], [47:40] and [39:32], and a 32-bit immediate in [31:0]. The low six bits of an operand field select one of 64 general registers of 32 bits.

Top module: `tq_issue_core`

## Requirements
- R1: After reset `stopped` is 1, `q_push` is 0, and every register and latched parameter is zero.
- R2: A `start` pulse while stopped begins execution at address 0 and drops `stopped` on the next cycle.
- R3: MOVE (0x02) writes the immediate to register C. ADD (0x03) writes A+B to C. ADDI (0x04) writes A+immediate to C. All arithmetic wraps modulo 2^32.
- R4: LOOP (0x05) writes register A minus one back to A. It jumps to the immediate when the result is nonzero and falls through when it is zero.
- R5: JMP (0x06) and taken loops continue at the absolute address in the immediate. A taken jump costs one bubble cycle, while sequential timed instructions issue on consecutive cycles.
- R6: SETOFFS (0x10) latches offset0=imm[15:0] and offset1=imm[31:16]. SETFREQ (0x11) latches freq=imm. SETCOND (0x12) latches cond=imm[7:0]. None of these pushes anything. `q_param` is {cond, freq, offset1, offset0} from MSB to LSB.
- R7: The timed opcodes UPD 0x20, PLAY 0x21 and WAIT 0x22 push with `q_dur` = immediate. Their register forms 0x28, 0x29 and 0x2A push with `q_dur` = register A. `q_op` carries the opcode, and `q_param` carries the parameters latched before the push.
- R8: While `q_full` is high, `q_push` stays low and the pending timed instruction is held. Once the queue clears, it is pushed unchanged and execution resumes in order.
- R9: STOP (0x01) is pushed with `q_op`=0x01 and `q_dur`=immediate. `stopped` then rises and no further push occurs. A new `start` reruns the program from address 0 and keeps the register and parameter contents.
- R10: A write on the load port stores `imem_wdata` at `imem_waddr`, and later runs use the new word.
- R11: Opcodes outside the defined set act as no-operation: they write no register, latch no parameter and push nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin execution at address 0 when stopped |
| imem_we | input | 1 | Instruction memory write enable |
| imem_waddr | input | AW (10) | Instruction memory write address |
| imem_wdata | input | 64 | Instruction word to store |
| q_full | input | 1 | Downstream queue full; stalls a pending timed instruction |
| q_push | output | 1 | Timed instruction handed to the queue this cycle |
| q_op | output | 8 | Opcode of the pushed instruction |
| q_dur | output | 32 | Duration of the pushed instruction |
| q_param | output | 72 | Snapshot of latched parameters {cond, freq, offset1, offset0} |
| stopped | output | 1 | Core is not running (after reset or after STOP) |

## Verification
The hardest case to reach from the ports is a timed instruction held by backpressure while parameter writes sit on both sides of it. The stall must neither drop the held entry nor let a later parameter write leak into its snapshot. The bench raises `q_full` before `start`, so the first timed instruction reaches the head and waits. It watches for several cycles that nothing is pushed and the core stays running, then releases the queue and checks each entry's snapshot and order. Register values are otherwise invisible, so they are observed through the register-duration forms of WAIT. Jump bubbles are measured as cycle gaps between consecutive pushes.

// File: rtl/tq_pkg.sv
package tq_pkg;

    localparam int OPW  = 8;
    localparam int IMMW = 32;

    localparam logic [7:0] OP_NOP     = 8'h00;
    localparam logic [7:0] OP_STOP    = 8'h01;
    localparam logic [7:0] OP_MOVE    = 8'h02;
    localparam logic [7:0] OP_ADD     = 8'h03;
    localparam logic [7:0] OP_ADDI    = 8'h04;
    localparam logic [7:0] OP_LOOP    = 8'h05;
    localparam logic [7:0] OP_JMP     = 8'h06;
    localparam logic [7:0] OP_SETOFFS = 8'h10;
    localparam logic [7:0] OP_SETFREQ = 8'h11;
    localparam logic [7:0] OP_SETCOND = 8'h12;
    localparam logic [7:0] OP_UPD     = 8'h20;
    localparam logic [7:0] OP_PLAY    = 8'h21;
    localparam logic [7:0] OP_WAIT    = 8'h22;
    localparam logic [7:0] OP_UPDR    = 8'h28;
    localparam logic [7:0] OP_PLAYR   = 8'h29;
    localparam logic [7:0] OP_WAITR   = 8'h2A;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_HALT = 2'd2
    } run_state_e;

    typedef struct packed {
        logic [7:0]  op;
        logic [7:0]  fa;
        logic [7:0]  fb;
        logic [7:0]  fc;
        logic [31:0] imm;
    } instr_t;

    typedef struct packed {
        logic [7:0]  cond;
        logic [31:0] freq;
        logic [15:0] offs1;
        logic [15:0] offs0;
    } params_t;

    localparam int INSTR_W  = $bits(instr_t);
    localparam int PARAMS_W = $bits(params_t);

    function automatic logic op_is_timed(input logic [7:0] op);
        return (op == OP_STOP)  || (op == OP_UPD)  || (op == OP_PLAY) ||
               (op == OP_WAIT)  || (op == OP_UPDR) || (op == OP_PLAYR) ||
               (op == OP_WAITR);
    endfunction

    function automatic logic op_dur_from_reg(input logic [7:0] op);
        return (op == OP_UPDR) || (op == OP_PLAYR) || (op == OP_WAITR);
    endfunction

endpackage

// File: rtl/tq_imem.sv
module tq_imem #(
    parameter int DEPTH = 1024,
    parameter int WIDTH = 64,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             we,
    input  logic [AW-1:0]    waddr,
    input  logic [WIDTH-1:0] wdata,
    input  logic             re,
    input  logic [AW-1:0]    raddr,
    output logic [WIDTH-1:0] rdata
);
    logic [WIDTH-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
        if (re) rdata <= mem[raddr];
    end
endmodule

// File: rtl/tq_regfile.sv
module tq_regfile #(
    parameter int NREG = 64,
    parameter int DW   = 32,
    localparam int RAW = $clog2(NREG)
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           we,
    input  logic [RAW-1:0] waddr,
    input  logic [DW-1:0]  wdata,
    input  logic [RAW-1:0] raddr_a,
    input  logic [RAW-1:0] raddr_b,
    output logic [DW-1:0]  rdata_a,
    output logic [DW-1:0]  rdata_b
);
    logic [DW-1:0] regs [NREG];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NREG; i++) regs[i] <= '0;
        end else if (we) begin
            regs[waddr] <= wdata;
        end
    end

    assign rdata_a = regs[raddr_a];
    assign rdata_b = regs[raddr_b];
endmodule

// File: rtl/tq_param_latch.sv
module tq_param_latch
    import tq_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        en,
    input  logic [7:0]  op,
    input  logic [31:0] imm,
    output params_t     params
);
    always_ff @(posedge clk) begin
        if (rst) begin
            params <= '0;
        end else if (en) begin
            case (op)
                OP_SETOFFS: begin
                    params.offs0 <= imm[15:0];
                    params.offs1 <= imm[31:16];
                end
                OP_SETFREQ: params.freq <= imm;
                OP_SETCOND: params.cond <= imm[7:0];
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/tq_issue_core.sv
module tq_issue_core
    import tq_pkg::*;
#(
    parameter int IMEM_DEPTH = 1024,
    parameter int NREG       = 64,
    localparam int AW        = $clog2(IMEM_DEPTH),
    localparam int RAW       = $clog2(NREG)
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                start,
    input  logic                imem_we,
    input  logic [AW-1:0]       imem_waddr,
    input  logic [INSTR_W-1:0]  imem_wdata,
    input  logic                q_full,
    output logic                q_push,
    output logic [7:0]          q_op,
    output logic [31:0]         q_dur,
    output logic [PARAMS_W-1:0] q_param,
    output logic                stopped
);
    run_state_e         state;
    logic [AW-1:0]      pc;
    logic               ir_valid;
    logic [INSTR_W-1:0] ir_raw;
    instr_t             ir;
    params_t            params;

    logic               fetch_en;
    logic [AW-1:0]      fetch_addr;
    logic [31:0]        rd_a, rd_b, loop_dec;
    logic               timed, stall, taken, exec;
    logic               rf_we;
    logic [RAW-1:0]     rf_waddr;
    logic [31:0]        rf_wdata;

    assign ir = instr_t'(ir_raw);

    // Decode and execute
    assign timed    = ir_valid && op_is_timed(ir.op);
    assign stall    = timed && q_full;
    assign exec     = ir_valid && !stall;
    assign loop_dec = rd_a - 32'd1;
    assign taken    = ir_valid && ((ir.op == OP_JMP) ||
                                   ((ir.op == OP_LOOP) && (loop_dec != 32'd0)));

    always_comb begin
        rf_we    = 1'b0;
        rf_waddr = ir.fc[RAW-1:0];
        rf_wdata = '0;
        if (exec) begin
            case (ir.op)
                OP_MOVE: begin rf_we = 1'b1; rf_wdata = ir.imm; end
                OP_ADD:  begin rf_we = 1'b1; rf_wdata = rd_a + rd_b; end
                OP_ADDI: begin rf_we = 1'b1; rf_wdata = rd_a + ir.imm; end
                OP_LOOP: begin
                    rf_we    = 1'b1;
                    rf_waddr = ir.fa[RAW-1:0];
                    rf_wdata = loop_dec;
                end
                default: ;
            endcase
        end
    end

    // Fetch address selection
    always_comb begin
        fetch_en   = 1'b0;
        fetch_addr = pc;
        if (state != ST_RUN) begin
            if (start) begin
                fetch_en   = 1'b1;
                fetch_addr = '0;
            end
        end else if (!ir_valid) begin
            fetch_en = 1'b1;
        end else if (exec && !taken && (ir.op != OP_STOP)) begin
            fetch_en = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_IDLE;
            pc       <= '0;
            ir_valid <= 1'b0;
        end else if (state != ST_RUN) begin
            if (start) begin
                state    <= ST_RUN;
                pc       <= AW'(1);
                ir_valid <= 1'b1;
            end
        end else if (!ir_valid) begin
            pc       <= pc + AW'(1);
            ir_valid <= 1'b1;
        end else if (!stall) begin
            if (ir.op == OP_STOP) begin
                state    <= ST_HALT;
                ir_valid <= 1'b0;
            end else if (taken) begin
                pc       <= ir.imm[AW-1:0];
                ir_valid <= 1'b0;
            end else begin
                pc <= pc + AW'(1);
            end
        end
    end

    tq_imem #(.DEPTH(IMEM_DEPTH), .WIDTH(INSTR_W)) u_imem (
        .clk   (clk),
        .we    (imem_we),
        .waddr (imem_waddr),
        .wdata (imem_wdata),
        .re    (fetch_en),
        .raddr (fetch_addr),
        .rdata (ir_raw)
    );

    tq_regfile #(.NREG(NREG), .DW(32)) u_rf (
        .clk     (clk),
        .rst     (rst),
        .we      (rf_we),
        .waddr   (rf_waddr),
        .wdata   (rf_wdata),
        .raddr_a (ir.fa[RAW-1:0]),
        .raddr_b (ir.fb[RAW-1:0]),
        .rdata_a (rd_a),
        .rdata_b (rd_b)
    );

    tq_param_latch u_par (
        .clk    (clk),
        .rst    (rst),
        .en     (exec),
        .op     (ir.op),
        .imm    (ir.imm),
        .params (params)
    );

    // Queue interface
    assign q_push  = timed && !q_full;
    assign q_op    = ir.op;
    assign q_dur   = op_dur_from_reg(ir.op) ? rd_a : ir.imm;
    assign q_param = params;
    assign stopped = (state != ST_RUN);

    logic unused_fields;
    assign unused_fields = ^{ir.fa[7:RAW], ir.fb[7:RAW], ir.fc[7:RAW], ir.imm[31:AW]};
endmodule

// File: rtl/tq_issue_core_chk.sv
module tq_issue_core_chk #(
    parameter int AW = 10
) (
    input logic          clk,
    input logic          rst,
    input logic          start,
    input logic          q_full,
    input logic          q_push,
    input logic [7:0]    q_op,
    input logic [31:0]   q_dur,
    input logic          stopped,
    input logic          ir_valid,
    input logic          stall,
    input logic          taken,
    input logic [AW-1:0] pc
);
    p_idle_quiet_r1: assert property (@(posedge clk) disable iff (rst)
        stopped |-> !q_push);

    p_start_runs_r2: assert property (@(posedge clk) disable iff (rst)
        (stopped && start) |=> !stopped);

    p_jump_bubble_r5: assert property (@(posedge clk) disable iff (rst)
        taken |=> (!ir_valid && !q_push));

    p_full_blocks_r8: assert property (@(posedge clk) disable iff (rst)
        q_full |-> !q_push);

    p_stall_holds_r8: assert property (@(posedge clk) disable iff (rst)
        stall |=> ($stable(pc) && $stable(q_op) && $stable(q_dur) && ir_valid));

    p_stop_halts_r9: assert property (@(posedge clk) disable iff (rst)
        (q_push && (q_op == 8'h01)) |=> stopped);
endmodule

bind tq_issue_core tq_issue_core_chk #(.AW(AW)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .start    (start),
    .q_full   (q_full),
    .q_push   (q_push),
    .q_op     (q_op),
    .q_dur    (q_dur),
    .stopped  (stopped),
    .ir_valid (ir_valid),
    .stall    (stall),
    .taken    (taken),
    .pc       (pc)
);

// File: tb/tq_issue_core_tb.sv
module tq_issue_core_tb;
    localparam int CLK_PERIOD = 10;
    localparam int AW = 10;
    localparam int WD_LIMIT = 150000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic        imem_we = 1'b0;
    logic [AW-1:0] imem_waddr = '0;
    logic [63:0] imem_wdata = '0;
    logic        q_full = 1'b0;
    logic        q_push;
    logic [7:0]  q_op;
    logic [31:0] q_dur;
    logic [71:0] q_param;
    logic        stopped;

    int total = 0;
    int bad = 0;
    int cyc = 0;

    logic [7:0]  log_op  [64];
    logic [31:0] log_dur [64];
    logic [71:0] log_par [64];
    int          log_cyc [64];
    int          n_log = 0;
    logic [63:0] prog [32];

    tq_issue_core u_dut (
        .clk(clk), .rst(rst), .start(start),
        .imem_we(imem_we), .imem_waddr(imem_waddr), .imem_wdata(imem_wdata),
        .q_full(q_full), .q_push(q_push), .q_op(q_op), .q_dur(q_dur),
        .q_param(q_param), .stopped(stopped)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc == WD_LIMIT) begin
            total++; bad++;
            $display("FAIL watchdog: act=%0d exp=<%0d cycles", cyc, WD_LIMIT);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    always @(negedge clk) begin
        if (!rst && q_push && n_log < 64) begin
            log_op[n_log]  = q_op;
            log_dur[n_log] = q_dur;
            log_par[n_log] = q_param;
            log_cyc[n_log] = cyc;
            n_log++;
        end
    end

    function automatic logic [63:0] enc(input logic [7:0] op, input logic [7:0] a,
                                        input logic [7:0] b, input logic [7:0] c,
                                        input logic [31:0] imm);
        return {op, a, b, c, imm};
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [71:0] act, input logic [71:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: act=%0h exp=%0h", req, what, act, exp);
        end
    endtask

    task automatic load(input int len);
        for (int i = 0; i < len; i++) begin
            @(posedge clk); #1;
            imem_we = 1'b1; imem_waddr = AW'(i); imem_wdata = prog[i];
        end
        @(posedge clk); #1;
        imem_we = 1'b0;
    endtask

    task automatic pulse_start();
        n_log = 0;
        @(posedge clk); #1 start = 1'b1;
        @(posedge clk); #1 start = 1'b0;
    endtask

    task automatic wait_stop();
        for (int i = 0; i < 5000; i++) begin
            @(negedge clk);
            if (stopped) break;
        end
        repeat (2) @(negedge clk);
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk(stopped == 1'b1, "R1", "stopped after reset", 72'(stopped), 72'd1);
        chk(q_push == 1'b0, "R1", "no push after reset", 72'(q_push), 72'd0);
    endtask

    task automatic t_arith();
        prog[0] = enc(8'h02, 0, 0, 1, 32'd7);
        prog[1] = enc(8'h02, 0, 0, 2, 32'hFFFF_FFFF);
        prog[2] = enc(8'h00, 0, 0, 0, 0);
        prog[3] = enc(8'h03, 1, 2, 3, 0);
        prog[4] = enc(8'h04, 1, 0, 4, 32'd100);
        prog[5] = enc(8'h2A, 3, 0, 0, 0);
        prog[6] = enc(8'h2A, 4, 0, 0, 0);
        prog[7] = enc(8'h01, 0, 0, 0, 32'd4);
        load(8);
        @(negedge clk);
        chk(stopped == 1'b1, "R2", "still stopped before start", 72'(stopped), 72'd1);
        pulse_start();
        @(negedge clk);
        chk(stopped == 1'b0, "R2", "running after start", 72'(stopped), 72'd0);
        wait_stop();
        chk(n_log == 3, "R3", "push count", 72'(n_log), 72'd3);
        chk(log_dur[0] == 32'd6, "R3", "add wraps 7+ffffffff", 72'(log_dur[0]), 72'd6);
        chk(log_dur[1] == 32'd107, "R3", "addi 7+100", 72'(log_dur[1]), 72'd107);
        chk(log_op[0] == 8'h2A, "R7", "op of register wait", 72'(log_op[0]), 72'h2A);
        chk(log_par[0] == 72'd0, "R1", "params zero from reset", log_par[0], 72'd0);
        chk(log_op[2] == 8'h01 && log_dur[2] == 32'd4, "R9", "stop pushed",
            {log_op[2], log_dur[2]}, {8'h01, 32'd4});
    endtask

    task automatic t_loop_mul();
        prog[0] = enc(8'h02, 0, 0, 0, 32'd0);
        prog[1] = enc(8'h02, 0, 0, 1, 32'd100);
        prog[2] = enc(8'h02, 0, 0, 2, 32'd21);
        prog[3] = enc(8'h03, 0, 1, 0, 0);
        prog[4] = enc(8'h05, 2, 0, 0, 32'd3);
        prog[5] = enc(8'h2A, 0, 0, 0, 0);
        prog[6] = enc(8'h01, 0, 0, 0, 0);
        load(7);
        pulse_start();
        wait_stop();
        chk(n_log == 2, "R4", "mul push count", 72'(n_log), 72'd2);
        chk(log_dur[0] == 32'd2100, "R4", "100x21 by loop", 72'(log_dur[0]), 72'd2100);
    endtask

    task automatic t_loop_timing();
        prog[0] = enc(8'h02, 0, 0, 5, 32'd3);
        prog[1] = enc(8'h00, 0, 0, 0, 0);
        prog[2] = enc(8'h22, 0, 0, 0, 32'd9);
        prog[3] = enc(8'h05, 5, 0, 0, 32'd2);
        prog[4] = enc(8'h01, 0, 0, 0, 0);
        load(5);
        pulse_start();
        wait_stop();
        chk(n_log == 4, "R4", "three iterations plus stop", 72'(n_log), 72'd4);
        chk(log_dur[2] == 32'd9 && log_op[2] == 8'h22, "R7", "immediate wait",
            {log_op[2], log_dur[2]}, {8'h22, 32'd9});
        chk(log_cyc[1] - log_cyc[0] == 3, "R5", "taken loop gap", 72'(log_cyc[1] - log_cyc[0]), 72'd3);
        chk(log_cyc[3] - log_cyc[2] == 2, "R4", "fall-through gap", 72'(log_cyc[3] - log_cyc[2]), 72'd2);
    endtask

    task automatic t_jump();
        prog[0] = enc(8'h06, 0, 0, 0, 32'd3);
        prog[1] = enc(8'h22, 0, 0, 0, 32'd1);
        prog[2] = enc(8'h22, 0, 0, 0, 32'd2);
        prog[3] = enc(8'h22, 0, 0, 0, 32'd3);
        prog[4] = enc(8'h01, 0, 0, 0, 0);
        load(5);
        pulse_start();
        wait_stop();
        chk(n_log == 2, "R5", "skipped lines", 72'(n_log), 72'd2);
        chk(log_dur[0] == 32'd3, "R5", "absolute target", 72'(log_dur[0]), 72'd3);
        chk(log_cyc[1] - log_cyc[0] == 1, "R5", "sequential gap", 72'(log_cyc[1] - log_cyc[0]), 72'd1);
    endtask

    task automatic t_params();
        prog[0] = enc(8'h10, 0, 0, 0, 32'h1234_5678);
        prog[1] = enc(8'h11, 0, 0, 0, 32'hABCD_0001);
        prog[2] = enc(8'h12, 0, 0, 0, 32'h0000_0005);
        prog[3] = enc(8'h21, 0, 0, 0, 32'd20);
        prog[4] = enc(8'h10, 0, 0, 0, 32'h0);
        prog[5] = enc(8'h20, 0, 0, 0, 32'd4);
        prog[6] = enc(8'h22, 0, 0, 0, 32'd8);
        prog[7] = enc(8'h01, 0, 0, 0, 0);
        load(8);
        pulse_start();
        wait_stop();
        chk(n_log == 4, "R6", "param writes push nothing", 72'(n_log), 72'd4);
        chk(log_par[0] == {8'd5, 32'hABCD_0001, 16'h1234, 16'h5678}, "R6", "snapshot at play",
            log_par[0], {8'd5, 32'hABCD_0001, 16'h1234, 16'h5678});
        chk(log_par[1] == {8'd5, 32'hABCD_0001, 32'h0}, "R6", "offset cleared, rest kept",
            log_par[1], {8'd5, 32'hABCD_0001, 32'h0});
        chk(log_op[1] == 8'h20 && log_dur[1] == 32'd4, "R7", "update entry",
            {log_op[1], log_dur[1]}, {8'h20, 32'd4});
    endtask

    task automatic t_stall();
        prog[0] = enc(8'h10, 0, 0, 0, 32'h0001_0002);
        prog[1] = enc(8'h20, 0, 0, 0, 32'd10);
        prog[2] = enc(8'h10, 0, 0, 0, 32'h0003_0004);
        prog[3] = enc(8'h20, 0, 0, 0, 32'd11);
        prog[4] = enc(8'h01, 0, 0, 0, 0);
        load(5);
        q_full = 1'b1;
        pulse_start();
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            chk(q_push == 1'b0, "R8", "no push while full", 72'(q_push), 72'd0);
        end
        chk(stopped == 1'b0, "R8", "held, not halted", 72'(stopped), 72'd0);
        @(posedge clk); #1 q_full = 1'b0;
        wait_stop();
        chk(n_log == 3, "R8", "entries after release", 72'(n_log), 72'd3);
        chk(log_dur[0] == 32'd10 && log_par[0][31:0] == 32'h0001_0002, "R8",
            "held entry snapshot", {log_dur[0], log_par[0][31:0]}, {32'd10, 32'h0001_0002});
        chk(log_dur[1] == 32'd11 && log_par[1][31:0] == 32'h0003_0004, "R8",
            "second entry snapshot", {log_dur[1], log_par[1][31:0]}, {32'd11, 32'h0003_0004});
    endtask

    task automatic t_unknown_restart();
        prog[0] = enc(8'h02, 0, 0, 9, 32'd5);
        prog[1] = enc(8'h00, 0, 0, 0, 0);
        prog[2] = enc(8'h7F, 9, 9, 9, 32'd77);
        prog[3] = enc(8'h00, 0, 0, 0, 0);
        prog[4] = enc(8'h2A, 9, 0, 0, 0);
        prog[5] = enc(8'h01, 0, 0, 0, 0);
        load(6);
        pulse_start();
        wait_stop();
        chk(n_log == 2, "R11", "unknown pushes nothing", 72'(n_log), 72'd2);
        chk(log_dur[0] == 32'd5, "R11", "unknown leaves register", 72'(log_dur[0]), 72'd5);
        chk(log_par[0][31:0] == 32'h0003_0004, "R11", "unknown leaves params",
            72'(log_par[0][31:0]), 72'h0003_0004);
        // Rerun after halt, with one word replaced through the load port
        @(posedge clk); #1;
        imem_we = 1'b1; imem_waddr = AW'(4); imem_wdata = enc(8'h22, 0, 0, 0, 32'd13);
        @(posedge clk); #1 imem_we = 1'b0;
        pulse_start();
        wait_stop();
        chk(n_log == 2, "R9", "restart from zero", 72'(n_log), 72'd2);
        chk(log_dur[0] == 32'd13 && log_op[0] == 8'h22, "R10", "rewritten word used",
            {log_op[0], log_dur[0]}, {8'h22, 32'd13});
        repeat (3) @(negedge clk);
        chk(stopped == 1'b1 && q_push == 1'b0, "R9", "quiet after stop",
            {stopped, q_push}, 72'b10);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        t_reset();
        t_arith();
        t_loop_mul();
        t_loop_timing();
        t_jump();
        t_params();
        t_stall();
        t_unknown_restart();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule